// File: doc/BRIEF.md
# Hexacopter Attitude Controller and Motor Mixer

This block turns pilot set-points and measured attitude into six motor duty commands for a six-rotor airframe. Each sample it forms an error for each of four axes (roll, pitch, yaw, thrust). Roll and pitch each run a proportional-integral-derivative law with a clamped integrator. Yaw and thrust use a proportional gain only. The four axis terms are then blended through a built-in six-motor table, and every motor value is clamped to the valid duty range.

A host writes the gains, the integrator limit and a run bit through a small write-only register port. Upstream logic pulses a sample strobe when fresh inputs are present. The block answers with a one-cycle valid pulse that marks the new duty set. While the run bit is clear, every duty output is held at zero and all loop memory is wiped, so a restart begins from a clean state.

Top module: `hex_attitude_ctrl`

## Requirements
- R1: After reset every motor duty is 0 and `motorValid` is low, and the run bit, all gains and the integrator limit are 0.
- R2: Each axis error is target minus measured (signed 16-bit inputs). The roll and pitch terms are each P+I+D. Here P = (kp·e)>>>8, I = (ki·acc)>>>8 and D = (kd·(e−ePrev))>>>8. Gains are signed Q8.8, where 256 means 1.0, and >>> rounds toward minus infinity.
- R3: On each update, the roll and pitch accumulators add the error and then saturate to ±limit, where the limit is an unsigned 16-bit register. The I term uses the accumulator value after this update.
- R4: The D term uses the error of the previous accepted sample. That previous error is 0 after reset and after a stop.
- R5: Yaw and thrust terms are proportional only: (kYaw·e)>>>8 and (kThr·e)>>>8. Roll and pitch gains are shared.
- R6: Motor m duty = floor((2·T + r[m]·R + p[m]·P + y[m]·Y)/2) for m = 0..5. The roll weights r are {−1,−2,−1,+1,+2,+1}. The pitch weights p are {+2,0,−2,−2,0,+2}. The yaw weights y are {+2,−2,+2,−2,+2,−2}, alternating between neighbours. Motor m occupies `motorDuty[12m+11:12m]`.
- R7: Each duty is clamped to 0..4095, where 4095 means full duty.
- R8: `motorValid` is a single-cycle pulse that rises after the third rising edge, counting the edge that samples `sampleStb`. The duty outputs change only together with that pulse.
- R9: A strobe that arrives while an update is in progress is ignored. It does not add a second update or a second valid pulse.
- R10: When the run bit is clear, the duties read 0 from the next edge onward and no valid pulse is produced. Strobes are ignored, and both accumulators and the previous errors are cleared.
- R11: Register writes take effect at the rising edge with `regWe` high. The address map is: 0 = run (bit 0), 1 = roll/pitch kp, 2 = roll/pitch ki, 3 = roll/pitch kd, 4 = yaw gain, 5 = thrust gain, 6 = integrator limit. Writes to addresses 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write enable |
| regAddr | input | 3 | Register address |
| regWdata | input | 16 | Register write data |
| sampleStb | input | 1 | New-sample strobe |
| tgtRoll | input | 16 | Roll set-point, signed |
| tgtPitch | input | 16 | Pitch set-point, signed |
| tgtYaw | input | 16 | Yaw set-point, signed |
| tgtThrust | input | 16 | Thrust set-point, signed |
| measRoll | input | 16 | Measured roll, signed |
| measPitch | input | 16 | Measured pitch, signed |
| measYaw | input | 16 | Measured yaw, signed |
| measThrust | input | 16 | Measured thrust feedback, signed |
| motorDuty | output | 72 | Six 12-bit duty commands |
| motorValid | output | 1 | New duty set pulse |

## Verification
The bench targets integrator saturation on both signs. A design without the clamp keeps growing the output after the limit is reached. The first derivative after a restart is also checked: if the previous error is not cleared, a stale difference is injected. Strobes held across a busy update are checked too, and a design that accepts them shows an extra valid pulse and a doubled integral on the next sample. Finally, the bench checks mixer weights, yaw sign alternation and both clamp rails. Swapped weights or a missing clamp show up as wrong per-motor duties or a value that wraps around.

// File: rtl/hac_pkg.sv
package hac_pkg;
  localparam int DATA_W      = 16;
  localparam int GAIN_W      = 16;
  localparam int GAIN_FRAC   = 8;
  localparam int DUTY_W      = 12;
  localparam int NUM_AXES    = 4;
  localparam int NUM_PID     = 2;
  localparam int NUM_MOTORS  = 6;
  localparam int ADDR_W      = 3;
  localparam int INTEG_GUARD = 8;

  localparam int AX_ROLL  = 0;
  localparam int AX_PITCH = 1;
  localparam int AX_YAW   = 2;
  localparam int AX_THR   = 3;

  localparam logic [ADDR_W-1:0] A_RUN  = 3'd0;
  localparam logic [ADDR_W-1:0] A_KP   = 3'd1;
  localparam logic [ADDR_W-1:0] A_KI   = 3'd2;
  localparam logic [ADDR_W-1:0] A_KD   = 3'd3;
  localparam logic [ADDR_W-1:0] A_KYAW = 3'd4;
  localparam logic [ADDR_W-1:0] A_KTHR = 3'd5;
  localparam logic [ADDR_W-1:0] A_ILIM = 3'd6;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic latch;
    logic pid;
    logic mix;
    logic clr;
  } ctl_t;

  typedef struct packed {
    logic                     run;
    logic signed [GAIN_W-1:0] kpRp;
    logic signed [GAIN_W-1:0] kiRp;
    logic signed [GAIN_W-1:0] kdRp;
    logic signed [GAIN_W-1:0] kpYaw;
    logic signed [GAIN_W-1:0] kpThr;
    logic        [DATA_W-1:0] iLim;
  } cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_PID, ST_MIX} state_t;

  // mixer weights in half units
  function automatic int rollHalf(int m);
    case (m)
      0: return -1;
      1: return -2;
      2: return -1;
      3: return 1;
      4: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int pitchHalf(int m);
    case (m)
      0, 5: return 2;
      2, 3: return -2;
      default: return 0;
    endcase
  endfunction

  function automatic int yawHalf(int m);
    return (m % 2 == 0) ? 2 : -2;
  endfunction
endpackage

// File: rtl/hac_regs.sv
module hac_regs
  import hac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output cfg_t              cfg
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (regWe) begin
      case (regAddr)
        A_RUN:  cfg.run   <= regWdata[0];
        A_KP:   cfg.kpRp  <= regWdata;
        A_KI:   cfg.kiRp  <= regWdata;
        A_KD:   cfg.kdRp  <= regWdata;
        A_KYAW: cfg.kpYaw <= regWdata;
        A_KTHR: cfg.kpThr <= regWdata;
        A_ILIM: cfg.iLim  <= regWdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hac_control.sv
module hac_control
  import hac_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic run,
  input  logic sampleStb,
  output ctl_t ctl
);
  state_t stQ, stD;

  always_comb begin
    ctl = '0;
    stD = stQ;
    if (!run) begin
      ctl.clr = 1'b1;
      stD     = ST_IDLE;
    end else begin
      case (stQ)
        ST_IDLE: if (sampleStb) begin
          ctl.latch = 1'b1;
          stD       = ST_PID;
        end
        ST_PID: begin
          ctl.pid = 1'b1;
          stD     = ST_MIX;
        end
        ST_MIX: begin
          ctl.mix = 1'b1;
          stD     = ST_IDLE;
        end
        default: stD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stQ <= ST_IDLE;
    else       stQ <= stD;
  end

  // R8, R9: never more than one strobe
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl));

  // R9: a busy sequencer never starts a new sample
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.latch |=> !ctl.latch);
endmodule

// File: rtl/hac_pid_axis.sv
module hac_pid_axis #(
  parameter int EW    = 17,
  parameter int GW    = 16,
  parameter int GFRAC = 8,
  parameter int IW    = 24,
  parameter int LW    = 16,
  parameter int PW    = 42
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clr,
  input  logic                 upd,
  input  logic signed [EW-1:0] err,
  input  logic signed [GW-1:0] kp,
  input  logic signed [GW-1:0] ki,
  input  logic signed [GW-1:0] kd,
  input  logic        [LW-1:0] lim,
  output logic signed [PW-1:0] term
);
  logic signed [IW-1:0] integQ, integNext;
  logic signed [EW-1:0] prevQ;
  logic signed [IW:0]   sumI, limPos, limNeg;
  logic signed [EW:0]   dErr;
  logic signed [PW-1:0] pProd, iProd, dProd, termNext;

  always_comb begin
    sumI   = (IW+1)'(integQ) + (IW+1)'(err);
    limPos = $signed({{(IW+1-LW){1'b0}}, lim});
    limNeg = -limPos;
    if (sumI > limPos)      integNext = IW'(limPos);
    else if (sumI < limNeg) integNext = IW'(limNeg);
    else                    integNext = IW'(sumI);
    dErr     = (EW+1)'(err) - (EW+1)'(prevQ);
    pProd    = PW'(kp) * PW'(err);
    iProd    = PW'(ki) * PW'(integNext);
    dProd    = PW'(kd) * PW'(dErr);
    termNext = (pProd >>> GFRAC) + (iProd >>> GFRAC) + (dProd >>> GFRAC);
  end

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      integQ <= '0;
      prevQ  <= '0;
      term   <= '0;
    end else if (upd) begin
      integQ <= integNext;
      prevQ  <= err;
      term   <= termNext;
    end
  end

  // R3: accumulator stays inside the programmed window
  p_integ_limit_r3: assert property (@(posedge clk) disable iff (!rstN || clr)
    upd |=> ((IW+1)'(integQ) <= $past(limPos)) && ((IW+1)'(integQ) >= $past(limNeg)));
endmodule

// File: rtl/hac_datapath.sv
module hac_datapath
  import hac_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  ctl_t                             ctl,
  input  cfg_t                             cfg,
  input  logic signed [DATA_W-1:0]         tgt  [NUM_AXES],
  input  logic signed [DATA_W-1:0]         meas [NUM_AXES],
  output logic [NUM_MOTORS*DUTY_W-1:0]     duty,
  output logic                             valid
);
  localparam int EW       = DATA_W + 1;
  localparam int IW       = DATA_W + INTEG_GUARD;
  localparam int PW       = GAIN_W + IW + 2;
  localparam int MW       = PW + 4;
  localparam int DUTY_MAX = (1 << DUTY_W) - 1;

  logic signed [EW-1:0]     errQ     [NUM_AXES];
  logic signed [PW-1:0]     axisTerm [NUM_AXES];
  logic        [DUTY_W-1:0] dutyNext [NUM_MOTORS];

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clr) begin
      for (int a = 0; a < NUM_AXES; a++) errQ[a] <= '0;
    end else if (ctl.latch) begin
      for (int a = 0; a < NUM_AXES; a++)
        errQ[a] <= EW'(tgt[a]) - EW'(meas[a]);
    end
  end

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    if (a < NUM_PID) begin : g_pid
      hac_pid_axis #(
        .EW(EW), .GW(GAIN_W), .GFRAC(GAIN_FRAC), .IW(IW), .LW(DATA_W), .PW(PW)
      ) u_pid (
        .clk  (clk),
        .rstN (rstN),
        .clr  (ctl.clr),
        .upd  (ctl.pid),
        .err  (errQ[a]),
        .kp   (cfg.kpRp),
        .ki   (cfg.kiRp),
        .kd   (cfg.kdRp),
        .lim  (cfg.iLim),
        .term (axisTerm[a])
      );
    end else begin : g_prop
      logic signed [GAIN_W-1:0] kSel;
      logic signed [PW-1:0]     prod;
      if (a == AX_YAW) begin : g_yaw
        assign kSel = cfg.kpYaw;
      end else begin : g_thr
        assign kSel = cfg.kpThr;
      end
      assign prod = PW'(kSel) * PW'(errQ[a]);
      always_ff @(posedge clk) begin
        if (!rstN || ctl.clr) axisTerm[a] <= '0;
        else if (ctl.pid)     axisTerm[a] <= prod >>> GAIN_FRAC;
      end
    end
  end

  for (genvar m = 0; m < NUM_MOTORS; m++) begin : g_motor
    localparam int RH = rollHalf(m);
    localparam int PH = pitchHalf(m);
    localparam int YH = yawHalf(m);
    logic signed [MW-1:0] mixSum, half;
    always_comb begin
      mixSum = MW'(2)  * MW'(axisTerm[AX_THR])
             + MW'(RH) * MW'(axisTerm[AX_ROLL])
             + MW'(PH) * MW'(axisTerm[AX_PITCH])
             + MW'(YH) * MW'(axisTerm[AX_YAW]);
      half = mixSum >>> 1;
      if (half < 0)                   dutyNext[m] = '0;
      else if (half > MW'(DUTY_MAX))  dutyNext[m] = DUTY_W'(DUTY_MAX);
      else                            dutyNext[m] = half[DUTY_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clr) begin
      duty  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= ctl.mix;
      if (ctl.mix)
        for (int m = 0; m < NUM_MOTORS; m++)
          duty[m*DUTY_W +: DUTY_W] <= dutyNext[m];
    end
  end

  // R10: stopping forces outputs to zero
  p_stop_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clr |=> (duty == '0) && !valid);

  // R8: valid is a single-cycle pulse
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> !valid);

  // R8: duties hold between pulses while running
  p_duty_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.run && $past(cfg.run) && !valid) |-> $stable(duty));
endmodule

// File: rtl/hex_attitude_ctrl.sv
module hex_attitude_ctrl
  import hac_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWe,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [DATA_W-1:0]             regWdata,
  input  logic                          sampleStb,
  input  logic signed [DATA_W-1:0]      tgtRoll,
  input  logic signed [DATA_W-1:0]      tgtPitch,
  input  logic signed [DATA_W-1:0]      tgtYaw,
  input  logic signed [DATA_W-1:0]      tgtThrust,
  input  logic signed [DATA_W-1:0]      measRoll,
  input  logic signed [DATA_W-1:0]      measPitch,
  input  logic signed [DATA_W-1:0]      measYaw,
  input  logic signed [DATA_W-1:0]      measThrust,
  output logic [NUM_MOTORS*DUTY_W-1:0]  motorDuty,
  output logic                          motorValid
);
  cfg_t cfg;
  ctl_t ctl;
  logic signed [DATA_W-1:0] tgtArr  [NUM_AXES];
  logic signed [DATA_W-1:0] measArr [NUM_AXES];

  assign tgtArr[AX_ROLL]   = tgtRoll;
  assign tgtArr[AX_PITCH]  = tgtPitch;
  assign tgtArr[AX_YAW]    = tgtYaw;
  assign tgtArr[AX_THR]    = tgtThrust;
  assign measArr[AX_ROLL]  = measRoll;
  assign measArr[AX_PITCH] = measPitch;
  assign measArr[AX_YAW]   = measYaw;
  assign measArr[AX_THR]   = measThrust;

  hac_regs u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .cfg      (cfg)
  );

  hac_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .run       (cfg.run),
    .sampleStb (sampleStb),
    .ctl       (ctl)
  );

  hac_datapath u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .cfg   (cfg),
    .tgt   (tgtArr),
    .meas  (measArr),
    .duty  (motorDuty),
    .valid (motorValid)
  );

  // R8: accepted strobe yields valid three edges later
  p_latency_r8: assert property (@(posedge clk) disable iff (!rstN || !cfg.run)
    ctl.latch |-> ##3 motorValid);
endmodule

// File: tb/hex_attitude_ctrl_tb.sv
`timescale 1ns/1ps
module hex_attitude_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic        sampleStb = 1'b0;
  logic signed [15:0] tR = 0, tP = 0, tY = 0, tT = 0, mR = 0, mP = 0, mY = 0, mT = 0;
  logic [71:0] motorDuty;
  logic        motorValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench-side mirror of programmed values and loop memory
  longint kp = 0, ki = 0, kd = 0, kyaw = 0, kthr = 0, lim = 0;
  longint acc [2] = '{0, 0};
  longint prv [2] = '{0, 0};
  longint lastDuty [6] = '{0, 0, 0, 0, 0, 0};
  longint rw [6] = '{-1, -2, -1, 1, 2, 1};
  longint pw [6] = '{2, 0, -2, -2, 0, 2};
  longint yw [6] = '{2, -2, 2, -2, 2, -2};

  always #2.5 clk = ~clk;

  hex_attitude_ctrl u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .sampleStb(sampleStb),
    .tgtRoll(tR), .tgtPitch(tP), .tgtYaw(tY), .tgtThrust(tT),
    .measRoll(mR), .measPitch(mP), .measYaw(mY), .measThrust(mT),
    .motorDuty(motorDuty), .motorValid(motorValid)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint dutyOf(int m);
    return longint'(motorDuty[m*12 +: 12]);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
    case (a)
      3'd0: if (!d[0]) begin
              acc = '{0, 0}; prv = '{0, 0};
              for (int m = 0; m < 6; m++) lastDuty[m] = 0;
            end
      3'd1: kp   = longint'($signed(d));
      3'd2: ki   = longint'($signed(d));
      3'd3: kd   = longint'($signed(d));
      3'd4: kyaw = longint'($signed(d));
      3'd5: kthr = longint'($signed(d));
      3'd6: lim  = longint'(d);
      default: ;
    endcase
  endtask

  task automatic setIn(input longint a0, a1, a2, a3, b0, b1, b2, b3);
    tR = 16'(a0); tP = 16'(a1); tY = 16'(a2); tT = 16'(a3);
    mR = 16'(b0); mP = 16'(b1); mY = 16'(b2); mT = 16'(b3);
  endtask

  // advances the model by one accepted sample and fills expected duties
  task automatic model(output longint ex [6]);
    longint e [4];
    longint tm [4];
    longint n, s;
    e[0] = longint'(tR) - longint'(mR);
    e[1] = longint'(tP) - longint'(mP);
    e[2] = longint'(tY) - longint'(mY);
    e[3] = longint'(tT) - longint'(mT);
    for (int a = 0; a < 2; a++) begin
      n = acc[a] + e[a];
      if (n > lim) n = lim;
      if (n < -lim) n = -lim;
      tm[a] = ((kp * e[a]) >>> 8) + ((ki * n) >>> 8) + ((kd * (e[a] - prv[a])) >>> 8);
      acc[a] = n;
      prv[a] = e[a];
    end
    tm[2] = (kyaw * e[2]) >>> 8;
    tm[3] = (kthr * e[3]) >>> 8;
    for (int m = 0; m < 6; m++) begin
      s = (2 * tm[3] + rw[m] * tm[0] + pw[m] * tm[1] + yw[m] * tm[2]) >>> 1;
      if (s < 0) s = 0;
      if (s > 4095) s = 4095;
      ex[m] = s;
    end
  endtask

  task automatic checkDuties(input string tag, input longint ex [6]);
    for (int m = 0; m < 6; m++) begin
      chk($sformatf("%s motor%0d", tag, m), dutyOf(m), ex[m]);
      lastDuty[m] = ex[m];
    end
  endtask

  // one strobe, latency and result check (R8)
  task automatic sample(input string tag);
    longint ex [6];
    @(negedge clk); sampleStb = 1'b1;
    @(negedge clk); sampleStb = 1'b0;
    @(negedge clk);
    chk({tag, " R8 no early valid"}, longint'(motorValid), 0);
    for (int m = 0; m < 6; m++)
      chk({tag, " R8 duty held before pulse"}, dutyOf(m), lastDuty[m]);
    @(negedge clk);
    chk({tag, " R8 valid on third edge"}, longint'(motorValid), 1);
    model(ex);
    checkDuties(tag, ex);
    @(negedge clk);
    chk({tag, " R8 valid single cycle"}, longint'(motorValid), 0);
  endtask

  task automatic t_reset();
    chk("R1 valid in reset", longint'(motorValid), 0);
    for (int m = 0; m < 6; m++) chk("R1 duty in reset", dutyOf(m), 0);
  endtask

  task automatic t_stopped_strobe(input string tag);
    int pulses = 0;
    @(negedge clk); sampleStb = 1'b1;
    @(negedge clk); sampleStb = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (motorValid) pulses++;
    end
    chk({tag, " R10 no pulse while stopped"}, pulses, 0);
    for (int m = 0; m < 6; m++) chk({tag, " R10 duty zero while stopped"}, dutyOf(m), 0);
  endtask

  task automatic t_prop();
    wr(3'd1, 16'd256); wr(3'd2, 16'd0); wr(3'd3, 16'd0);
    wr(3'd4, 16'd256); wr(3'd5, 16'd256); wr(3'd6, 16'd1000);
    wr(3'd0, 16'd1);
    setIn(1000, 0, 0, 2000, 0, 0, 0, 0);
    sample("R2 R6 roll");
    setIn(0, -600, 0, 2000, 0, 0, 0, 0);
    sample("R2 R6 pitch");
    setIn(0, 0, 300, 2000, 0, 0, 0, 0);
    sample("R5 R6 yaw alternation");
    wr(3'd4, 16'd128); wr(3'd5, 16'd384);
    setIn(500, 100, 700, 3000, 200, 300, 100, 1200);
    sample("R5 R2 measured subtraction");
  endtask

  task automatic t_integ();
    wr(3'd1, 16'd0); wr(3'd3, 16'd0); wr(3'd2, 16'd256); wr(3'd6, 16'd500);
    wr(3'd4, 16'd0); wr(3'd5, 16'd256);
    setIn(300, 0, 0, 2000, 0, 0, 0, 0);
    sample("R3 accumulate");
    sample("R3 saturate high");
    sample("R3 hold at limit");
    setIn(-900, 0, 0, 2000, 0, 0, 0, 0);
    sample("R3 swing");
    sample("R3 saturate low");
  endtask

  task automatic t_deriv();
    wr(3'd2, 16'd0); wr(3'd3, 16'd512);
    setIn(0, 100, 0, 2000, 0, 0, 0, 0);
    sample("R4 diff a");
    setIn(0, 400, 0, 2000, 0, 0, 0, 0);
    sample("R4 diff b");
    sample("R4 diff zero");
  endtask

  task automatic t_clamp();
    wr(3'd3, 16'd0); wr(3'd1, 16'd0); wr(3'd5, 16'd256);
    setIn(0, 0, 0, 6000, 0, 0, 0, 0);
    sample("R7 clamp high");
    setIn(0, 0, 0, -2000, 0, 0, 0, 0);
    sample("R7 clamp low");
    wr(3'd1, 16'd256);
    setIn(1500, 0, 0, 1000, 0, 0, 0, 0);
    sample("R7 partial clamp");
  endtask

  task automatic t_busy();
    longint ex [6];
    int pulses = 0;
    wr(3'd1, 16'd0); wr(3'd2, 16'd256); wr(3'd6, 16'd4000);
    setIn(200, 0, 0, 1000, 0, 0, 0, 0);
    @(negedge clk); sampleStb = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); sampleStb = 1'b0;
    chk("R9 valid with held strobe", longint'(motorValid), 1);
    model(ex);
    checkDuties("R9 single update", ex);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (motorValid) pulses++;
    end
    chk("R9 no extra pulse", pulses, 0);
    sample("R9 integral advanced once");
  endtask

  task automatic t_stop_restart();
    wr(3'd0, 16'd0);
    @(negedge clk);
    chk("R10 valid low after stop", longint'(motorValid), 0);
    for (int m = 0; m < 6; m++) chk("R10 duty zero after stop", dutyOf(m), 0);
    t_stopped_strobe("stopped");
    wr(3'd0, 16'd1);
    wr(3'd3, 16'd256);
    setIn(200, 50, 0, 1000, 0, 0, 0, 0);
    sample("R10 R4 restart from clean state");
  endtask

  task automatic t_unmapped();
    wr(3'd7, 16'hFFFF);
    sample("R11 unmapped write ignored");
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R8 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_stopped_strobe("R1 R10 after reset");
    t_prop();
    t_integ();
    t_deriv();
    t_clamp();
    t_busy();
    t_stop_restart();
    t_unmapped();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule